// File: doc/BRIEF.md
# Dual-Level Masked Interrupt Controller

This block gathers thirty level-sensitive peripheral request lines and two programmed (software) requests. It drives two request lines to a processor core: a normal-priority line `irq_o` and a fast line `fiq_o`. Each level has four registers on a small word-addressed bus:

- a raw view of the request levels;
- a set-only enable mask;
- a write-only mask-clear port;
- an active view, which is the raw view ANDed with the mask.

Software can enable or disable single sources without a read-modify-write. The hardware keeps any source from being enabled at both levels at once. Any fast-level activity is folded back in as source 0 of both levels.

Source numbering is fixed:

- Source 0 is the fast-level fold-back.
- Source 1 is the programmed interrupt of that level. It ignores the masks.
- Sources 2 to 31 come from `periph_req[0]` to `periph_req[29]`. Each line passes through one register stage before it counts.

There is no priority encoder and no vector output. The handler reads the active view and decides in software.

Top module: `dual_level_intc`

## Requirements
- R1: After reset, both enable masks and the software configuration read as zero, and `irq_o` and `fiq_o` are low while no programmed interrupt is configured.
- R2: A write to an enable register (IRQ offset 0x04, FIQ offset 0x14) ORs the written ones into that mask. Zeros in the written data leave mask bits unchanged. A read of the same offset returns the mask.
- R3: A write to a clear register (IRQ offset 0x08, FIQ offset 0x18) clears the mask bits written as one and leaves the others. Reads of a clear offset return zero.
- R4: The active register (IRQ offset 0x0C, FIQ offset 0x1C) equals raw AND mask for bits 31..2 and bit 0. `irq_o` is the OR of all 32 IRQ active bits.
- R5: `fiq_o` is the OR of FIQ active bits 31..1. The same value appears as bit 0 of both raw registers (IRQ offset 0x00, FIQ offset 0x10).
- R6: Setting a bit in one level's enable mask clears the same bit in the other level's mask on the same clock edge. Clearing a bit at both levels is allowed.
- R7: The software configuration register is at offset 0x20. Bit 1 drives bit 1 of the IRQ raw and active registers, and bit 2 drives bit 1 of the FIQ raw and active registers, whatever the masks hold. Other bits are reserved: they read as zero and writes to them have no effect.
- R8: A change on `periph_req[k]` shows up in raw/active bit k+2 and on the outputs after exactly one rising clock edge, and not before it.
- R9: Reads at undefined offsets return zero, and `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | 30 | Level requests for sources 2..31 |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench aims at four hazards:

- The cross-level clear. A design that skipped it would leave a source enabled at both levels, so `irq_o` would fire for a source that should only reach the fast line.
- The fold-back of fast activity into source 0. Without it, `irq_o` would stay low even with IRQ mask bit 0 set while the fast line is active.
- The programmed bits. A design that masked them would keep both outputs silent after a software request with empty masks.
- Reserved bits and the one-edge input latency. Errors there show up as stray readback bits, or as outputs that move one cycle early or late against the cycle-accurate model.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // word index (byte address / 4) of each register
    localparam logic [3:0] RI_IRQ_RAW  = 4'd0;
    localparam logic [3:0] RI_IRQ_SET  = 4'd1;
    localparam logic [3:0] RI_IRQ_CLR  = 4'd2;
    localparam logic [3:0] RI_IRQ_ACT  = 4'd3;
    localparam logic [3:0] RI_FIQ_RAW  = 4'd4;
    localparam logic [3:0] RI_FIQ_SET  = 4'd5;
    localparam logic [3:0] RI_FIQ_CLR  = 4'd6;
    localparam logic [3:0] RI_FIQ_ACT  = 4'd7;
    localparam logic [3:0] RI_SWI_CFG  = 4'd8;

    // bit positions of the programmed interrupts in the configuration word
    localparam int SWI_IRQ_BIT = 1;
    localparam int SWI_FIQ_BIT = 2;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= d[i];
        end
    end
endmodule

// File: rtl/intc_mask_pair.sv
module intc_mask_pair #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_set,
    input  logic            irq_clr,
    input  logic            fiq_set,
    input  logic            fiq_clr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] irq_en,
    output logic [NSRC-1:0] fiq_en
);
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        logic irq_on, irq_off, fiq_on, fiq_off;
        always_comb begin
            irq_on  = irq_set & wdata[i];
            fiq_on  = fiq_set & wdata[i];
            // own clear or the other level claiming the source; clear wins
            irq_off = (irq_clr & wdata[i]) | fiq_on;
            fiq_off = (fiq_clr & wdata[i]) | irq_on;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_en[i] <= 1'b0;
                fiq_en[i] <= 1'b0;
            end else begin
                irq_en[i] <= (irq_en[i] | irq_on) & ~irq_off;
                fiq_en[i] <= (fiq_en[i] | fiq_on) & ~fiq_off;
            end
        end
    end

    // R6: never enabled at both levels
    p_masks_disjoint_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_en & fiq_en) == '0);

    // R2: written ones are set on the next edge
    p_set_takes_r2: assert property (@(posedge clk) disable iff (rst)
        irq_set |=> ((irq_en & $past(wdata)) == $past(wdata)));

    // R3: written ones cleared, other bits untouched
    p_clr_only_r3: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> (((irq_en & $past(wdata)) == '0) &&
                     ((irq_en & ~$past(wdata)) == ($past(irq_en) & ~$past(wdata)))));

    // R6: a fast-level set removes the same bits from the normal mask
    p_cross_clear_r6: assert property (@(posedge clk) disable iff (rst)
        fiq_set |=> ((irq_en & $past(wdata)) == '0));
endmodule

// File: rtl/dual_level_intc.sv
module dual_level_intc #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-3:0]   periph_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    import intc_pkg::*;

    localparam int NPER = NSRC - 2;

    logic [3:0]      widx;
    logic [NPER-1:0] req_s;
    logic [NSRC-1:0] irq_en, fiq_en;
    logic            swi_irq, swi_fiq;
    logic [NSRC-1:0] irq_raw, fiq_raw, irq_act, fiq_act;
    logic [NSRC-1:1] fiq_act_hi;
    logic            fiq_any;
    logic            past_ok;

    assign widx = bus_addr[5:2];

    intc_sync #(.W(NPER)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (periph_req),
        .q   (req_s)
    );

    intc_mask_pair #(.NSRC(NSRC)) u_masks (
        .clk     (clk),
        .rst     (rst),
        .irq_set (bus_wr && widx == RI_IRQ_SET),
        .irq_clr (bus_wr && widx == RI_IRQ_CLR),
        .fiq_set (bus_wr && widx == RI_FIQ_SET),
        .fiq_clr (bus_wr && widx == RI_FIQ_CLR),
        .wdata   (bus_wdata),
        .irq_en  (irq_en),
        .fiq_en  (fiq_en)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            swi_irq <= 1'b0;
            swi_fiq <= 1'b0;
        end else if (bus_wr && widx == RI_SWI_CFG) begin
            swi_irq <= bus_wdata[SWI_IRQ_BIT];
            swi_fiq <= bus_wdata[SWI_FIQ_BIT];
        end
    end

    // fast-level status above bit 0 feeds the fold-back source
    always_comb begin
        fiq_act_hi          = '0;
        fiq_act_hi[NSRC-1:2] = req_s & fiq_en[NSRC-1:2];
        fiq_act_hi[1]        = swi_fiq;
        fiq_any              = |fiq_act_hi;
    end

    always_comb begin
        irq_raw = {req_s, swi_irq, fiq_any};
        fiq_raw = {req_s, swi_fiq, fiq_any};
        irq_act = {req_s & irq_en[NSRC-1:2], swi_irq, fiq_any & irq_en[0]};
        fiq_act = {fiq_act_hi, fiq_any & fiq_en[0]};
    end

    assign irq_o = |irq_act;
    assign fiq_o = fiq_any;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (widx)
                RI_IRQ_RAW: bus_rdata = irq_raw;
                RI_IRQ_SET: bus_rdata = irq_en;
                RI_IRQ_ACT: bus_rdata = irq_act;
                RI_FIQ_RAW: bus_rdata = fiq_raw;
                RI_FIQ_SET: bus_rdata = fiq_en;
                RI_FIQ_ACT: bus_rdata = fiq_act;
                RI_SWI_CFG: begin
                    bus_rdata[SWI_IRQ_BIT] = swi_irq;
                    bus_rdata[SWI_FIQ_BIT] = swi_fiq;
                end
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8: raw peripheral bits follow the inputs of the previous edge
    p_one_stage_r8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (irq_raw[NSRC-1:2] == $past(periph_req)));

    // R7: a programmed interrupt reaches its line regardless of masks
    p_swi_irq_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        swi_irq |-> irq_o);
    p_swi_fiq_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        swi_fiq |-> fiq_o);

    // R5: fast activity enabled as IRQ source 0 raises the normal line
    p_fold_back_r5: assert property (@(posedge clk) disable iff (rst)
        (fiq_o && irq_en[0]) |-> irq_o);

    // R9: idle bus returns zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_dual_level_intc.sv
`timescale 1ns/1ps
module test_dual_level_intc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] periph_req = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dual_level_intc i_dual_level_intc (
        .clk(clk), .rst(rst), .periph_req(periph_req),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // behavioural reference state
    bit [31:0] m_ien, m_fen;
    bit [29:0] m_req;
    bit        m_si, m_sf;

    always @(posedge clk) begin
        if (rst) begin
            m_ien = 0; m_fen = 0; m_req = 0; m_si = 0; m_sf = 0;
        end else begin
            m_req = periph_req;
            if (bus_wr) begin
                case (int'(bus_addr) / 4)
                    1: begin m_ien = m_ien | bus_wdata; m_fen = m_fen & ~bus_wdata; end
                    2: m_ien = m_ien & ~bus_wdata;
                    5: begin m_fen = m_fen | bus_wdata; m_ien = m_ien & ~bus_wdata; end
                    6: m_fen = m_fen & ~bus_wdata;
                    8: begin m_si = bus_wdata[1]; m_sf = bus_wdata[2]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic bit m_fiq();
        bit any = m_sf;
        for (int k = 2; k < 32; k++) if (m_req[k-2] && m_fen[k]) any = 1;
        return any;
    endfunction

    function automatic bit [31:0] m_view(int idx);
        bit [31:0] raw_i, raw_f, v;
        bit f = m_fiq();
        raw_i = {m_req, m_si, f};
        raw_f = {m_req, m_sf, f};
        case (idx)
            0: v = raw_i;
            1: v = m_ien;
            3: begin v = raw_i & m_ien; v[1] = m_si; end
            4: v = raw_f;
            5: v = m_fen;
            7: begin v = raw_f & m_fen; v[1] = m_sf; end
            8: v = {29'd0, m_sf, m_si, 1'b0};
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R4, R5, R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 irq_o", {31'd0, irq_o}, {31'd0, |m_view(3)});
            check("R5 fiq_o", {31'd0, fiq_o}, {31'd0, m_fiq()});
            if (bus_rd) check("R9 rdata", bus_rdata, m_view(int'(bus_addr) / 4));
            else        check("R9 idle", bus_rdata, 32'd0);
        end
    end

    task automatic wr(int a, bit [31:0] d);
        @(negedge clk); #1;
        bus_addr = a[5:0]; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd_expect(int a, bit [31:0] exp, string tag);
        @(negedge clk); #1;
        bus_addr = a[5:0]; bus_rd = 1;
        #0.5;
        check(tag, bus_rdata, exp);
        @(negedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic pin_expect(bit iv, bit fv, string tag);
        @(negedge clk); #1;
        check(tag, {30'd0, irq_o, fiq_o}, {30'd0, iv, fv});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual hung expected done");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 rst = 0;
        // R1 reset state
        rd_expect(8'h04, 0, "R1 irq mask");
        rd_expect(8'h14, 0, "R1 fiq mask");
        rd_expect(8'h20, 0, "R1 swi cfg");
        pin_expect(0, 0, "R1 outputs");
        // R2 set-only enable
        wr(8'h04, 32'h0000_00F0);
        rd_expect(8'h04, 32'h0000_00F0, "R2 set");
        wr(8'h04, 32'h0);
        rd_expect(8'h04, 32'h0000_00F0, "R2 zero no effect");
        rd_expect(8'h08, 0, "R3 clr reads zero");
        rd_expect(8'h2C, 0, "R9 undefined offset");
        // R8 latency: source 4 = periph_req[2]
        @(negedge clk); #1 periph_req[2] = 1;
        #0.5 check("R8 before edge", {31'd0, irq_o}, 0);
        @(negedge clk);
        check("R8 after edge", {31'd0, irq_o}, 1);
        rd_expect(8'h0C, 32'h0000_0010, "R4 active");
        // R6 cross clear
        wr(8'h14, 32'h0000_0030);
        rd_expect(8'h04, 32'h0000_00C0, "R6 irq mask cleared");
        rd_expect(8'h14, 32'h0000_0030, "R6 fiq mask");
        pin_expect(0, 1, "R6 source moved to fast");
        rd_expect(8'h00, 32'h0000_0011, "R5 fold in irq raw");
        rd_expect(8'h10, 32'h0000_0011, "R5 fold in fiq raw");
        wr(8'h04, 32'h1);
        pin_expect(1, 1, "R5 fold raises irq");
        // R3 clear
        wr(8'h08, 32'h0000_0041);
        rd_expect(8'h04, 32'h0000_0080, "R3 clear partial");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_expect(8'h14, 0, "R3 fiq clear");
        pin_expect(0, 0, "R3 outputs low");
        // R7 programmed interrupts bypass empty masks
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'h2);
        pin_expect(1, 0, "R7 swi irq");
        rd_expect(8'h0C, 32'h0000_0002, "R7 irq active bit1");
        wr(8'h20, 32'hFFFF_FFFF);
        rd_expect(8'h20, 32'h0000_0006, "R7 reserved bits");
        pin_expect(1, 1, "R7 swi fiq");
        wr(8'h20, 32'h0);
        pin_expect(0, 0, "R7 swi off");
        // random phase compared by the model every cycle
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk); #1;
            periph_req = $urandom;
            bus_wr = ($urandom % 3) == 0;
            bus_rd = !bus_wr && ($urandom % 2);
            bus_addr = 6'(($urandom % 10) * 4);
            bus_wdata = $urandom;
        end
        @(negedge clk); #1 bus_wr = 0; bus_rd = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule